// File: doc/BRIEF.md
# Serial Flash Deep Power-Down Release and Signature Responder

This block is the slave-side logic of a serial flash device. It handles a single command: the one that wakes the device from deep power-down and reports an 8-bit electronic signature. The block samples the chip-select, serial-clock and serial-data-in pins into the system clock domain and decodes the opcode. It then lets the dummy header pass and shifts the signature out on a tri-stateable data line. The line is given as a data bit plus an output enable. The signature value is a parameter.

The block also owns the power-mode state, which is one of deep power-down, waking or standby. A completed command that was issued from deep power-down does not give standby at once. Instead a wake-up timer starts when chip select is released, and it counts a parameterised number of system clock cycles. While the timer runs, a busy flag is high and any new command frame is ignored.

Top module: `dpd_release_resp`

## Requirements
- R1: After reset, `pwr_state` is deep power-down (encoding 2'b01, when `RESET_IN_DPD`=1), `busy` is 0 and `miso_oe` is 0.
- R2: The opcode is 8'hAB, sampled MSB first on rising SCK edges. A frame with any other opcode never drives `miso_oe` and leaves `pwr_state` unchanged.
- R3: `miso_oe` stays 0 during the first 8+8*`DUMMY_BYTES` rising SCK edges of a frame (32 with the default of three dummy bytes).
- R4: After that header, the signature is driven MSB first. Each bit changes on a falling SCK edge, and the first bit is driven on the falling edge that follows the last header rising edge. The signature repeats every 8 clocks for as long as SCK runs with chip select low.
- R5: `miso_oe` is 0 whenever chip select has been high for more than the synchronizer latency.
- R6: A chip-select rise after at least one full signature has been clocked (header plus 8 rising edges) moves the state from deep power-down to waking (2'b10). `busy` is then 1 for exactly `T_RES_CYCLES` system clocks, after which the state is standby (2'b00).
- R7: A chip-select rise before a full signature has been clocked aborts the command and leaves `pwr_state` unchanged.
- R8: A completed command issued in standby leaves the state in standby at once, and `busy` never rises.
- R9: A frame whose chip-select fall arrives while `busy` is 1 is ignored for its whole length: `miso_oe` stays 0. The wake-up timer still reaches standby on schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; pins are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out value |
| miso_oe | output | 1 | Output enable for the serial data out (0 = high impedance) |
| pwr_state | output | 2 | Power mode: 2'b00 standby, 2'b01 deep power-down, 2'b10 waking |
| busy | output | 1 | High while the wake-up timer runs |

## Verification
The bench builds the block with `T_RES_CYCLES`=20 and `SIGNATURE`=8'h5C, keeping the default three dummy bytes. The short wake-up time lets the bench measure the busy window cycle-exactly. It also lets a new frame start inside that window, which is how the ignore rule is tested. The mixed-bit signature exposes bit-order and repeat-phase errors across two consecutive signature repeats. A second reset brings the block back to deep power-down, so that both the timed wake path and the immediate standby path are reached in one run.

// File: rtl/dpd_resp_pkg.sv
package dpd_resp_pkg;

  typedef enum logic [1:0] {
    PWR_STANDBY = 2'b00,
    PWR_DEEP    = 2'b01,
    PWR_WAKING  = 2'b10
  } pwr_state_e;

  localparam logic [7:0] WAKE_SIG_OPCODE = 8'hAB;
  localparam int unsigned OPC_BITS = 8;
  localparam int unsigned SIG_BITS = 8;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned    WIDTH   = 3,
  parameter int unsigned    STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES:0] sh_q;
    logic [STAGES:0] sh_d;

    always_comb sh_d = {sh_q[STAGES-1:0], pin_i[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {(STAGES+1){RST_VAL[g]}};
      else        sh_q <= sh_d;
    end

    assign lvl_o[g]  = sh_q[STAGES-1];
    assign rise_o[g] = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o[g] = ~sh_q[STAGES-1] & sh_q[STAGES];
  end

endmodule

// File: rtl/res_frame.sv
module res_frame
  import dpd_resp_pkg::*;
#(
  parameter logic [7:0]  SIGNATURE   = 8'h12,
  parameter int unsigned DUMMY_BYTES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_lvl,
  input  logic cs_fall,
  input  logic cs_rise,
  input  logic sck_rise,
  input  logic sck_fall,
  input  logic mosi_lvl,
  input  logic busy_i,
  output logic so_o,
  output logic so_oe_o,
  output logic done_o
);

  localparam int unsigned HDR_BITS = OPC_BITS + 8 * DUMMY_BYTES;
  localparam int unsigned LAST     = HDR_BITS + SIG_BITS - 1;
  localparam int unsigned CW       = $clog2(LAST + 1);
  localparam logic [CW-1:0] OPC_LAST_C = CW'(OPC_BITS - 1);
  localparam logic [CW-1:0] HDR_C      = CW'(HDR_BITS);
  localparam logic [CW-1:0] LAST_C     = CW'(LAST);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [6:0]    opc_q, opc_d;
  logic          hit_q, hit_d;
  logic          rd_q, rd_d;
  logic          ign_q, ign_d;
  logic          so_q, so_d;
  logic          oe_q, oe_d;
  logic          done;

  always_comb begin
    cnt_d = cnt_q;
    opc_d = opc_q;
    hit_d = hit_q;
    rd_d  = rd_q;
    ign_d = ign_q;
    so_d  = so_q;
    oe_d  = oe_q;
    done  = 1'b0;
    if (cs_fall) begin
      cnt_d = '0;
      hit_d = 1'b0;
      rd_d  = 1'b0;
      ign_d = busy_i;
      oe_d  = 1'b0;
    end else if (cs_lvl) begin
      oe_d = 1'b0;
      done = cs_rise & hit_q & rd_q & ~ign_q;
    end else if (!ign_q) begin
      if (sck_rise) begin
        if (cnt_q < OPC_LAST_C) begin
          opc_d = {opc_q[5:0], mosi_lvl};
          cnt_d = cnt_q + 1'b1;
        end else if (cnt_q == OPC_LAST_C) begin
          hit_d = ({opc_q, mosi_lvl} == WAKE_SIG_OPCODE);
          cnt_d = cnt_q + 1'b1;
        end else if (hit_q) begin
          if (cnt_q == LAST_C) begin
            cnt_d = HDR_C;
            rd_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      if (sck_fall && hit_q && (cnt_q >= HDR_C)) begin
        oe_d = 1'b1;
        so_d = SIGNATURE[~cnt_q[2:0]];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      opc_q <= '0;
      hit_q <= 1'b0;
      rd_q  <= 1'b0;
      ign_q <= 1'b0;
      so_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      opc_q <= opc_d;
      hit_q <= hit_d;
      rd_q  <= rd_d;
      ign_q <= ign_d;
      so_q  <= so_d;
      oe_q  <= oe_d;
    end
  end

  assign so_o    = so_q;
  assign so_oe_o = oe_q;
  assign done_o  = done;

endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import dpd_resp_pkg::*;
#(
  parameter int unsigned T_RES_CYCLES = 300,
  parameter bit          RESET_IN_DPD = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done_i,
  output pwr_state_e state_o,
  output logic       busy_o
);

  localparam int unsigned TW = (T_RES_CYCLES < 2) ? 1 : $clog2(T_RES_CYCLES);
  localparam logic [TW-1:0] TMR_LOAD = TW'(T_RES_CYCLES - 1);
  localparam pwr_state_e RST_STATE = RESET_IN_DPD ? PWR_DEEP : PWR_STANDBY;

  pwr_state_e    state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    unique case (state_q)
      PWR_DEEP: begin
        if (done_i) begin
          state_d = PWR_WAKING;
          tmr_d   = TMR_LOAD;
        end
      end
      PWR_WAKING: begin
        if (tmr_q == '0) state_d = PWR_STANDBY;
        else             tmr_d   = tmr_q - 1'b1;
      end
      default: state_d = PWR_STANDBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RST_STATE;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  assign state_o = state_q;
  assign busy_o  = (state_q == PWR_WAKING);

endmodule

// File: rtl/dpd_release_resp.sv
module dpd_release_resp
  import dpd_resp_pkg::*;
#(
  parameter logic [7:0]  SIGNATURE    = 8'h12,
  parameter int unsigned DUMMY_BYTES  = 3,
  parameter int unsigned T_RES_CYCLES = 300,
  parameter bit          RESET_IN_DPD = 1'b1,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  output logic       miso_o,
  output logic       miso_oe,
  output logic [1:0] pwr_state,
  output logic       busy
);

  localparam int unsigned NPIN = 3;

  logic [NPIN-1:0] lvl, rise, fall;
  logic            cs_s, cs_fall, cs_rise, sck_rise, sck_fall, mosi_s;
  logic            cmd_done;
  pwr_state_e      st;

  pin_sync #(
    .WIDTH  (NPIN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b001)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({mosi, sck, cs_n}),
    .lvl_o (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign cs_s     = lvl[0];
  assign cs_rise  = rise[0];
  assign cs_fall  = fall[0];
  assign sck_rise = rise[1];
  assign sck_fall = fall[1];
  assign mosi_s   = lvl[2];

  res_frame #(
    .SIGNATURE  (SIGNATURE),
    .DUMMY_BYTES(DUMMY_BYTES)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_lvl  (cs_s),
    .cs_fall (cs_fall),
    .cs_rise (cs_rise),
    .sck_rise(sck_rise),
    .sck_fall(sck_fall),
    .mosi_lvl(mosi_s),
    .busy_i  (busy),
    .so_o    (miso_o),
    .so_oe_o (miso_oe),
    .done_o  (cmd_done)
  );

  pwr_wake_ctrl #(
    .T_RES_CYCLES(T_RES_CYCLES),
    .RESET_IN_DPD(RESET_IN_DPD)
  ) u_pwr (
    .clk    (clk),
    .rst_n  (rst_n),
    .done_i (cmd_done),
    .state_o(st),
    .busy_o (busy)
  );

  assign pwr_state = st;

endmodule

// File: rtl/dpd_resp_chk.sv
module dpd_resp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic       sck_fall,
  input logic       miso_oe,
  input logic       busy,
  input logic [1:0] pwr_state
);

  assert_hiz_deselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> !miso_oe);

  assert_drive_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> $past(sck_fall));

  assert_wake_from_deep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(pwr_state) == 2'b01));

  assert_wake_ends_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (pwr_state == 2'b00));

  assert_standby_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b00) |=> (pwr_state == 2'b00));

  assert_quiet_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !miso_oe);

endmodule

bind dpd_release_resp dpd_resp_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_s     (cs_s),
  .sck_fall (sck_fall),
  .miso_oe  (miso_oe),
  .busy     (busy),
  .pwr_state(pwr_state)
);

// File: tb/dpd_release_resp_tb_top.sv
module dpd_release_resp_tb_top;

  localparam logic [7:0] SIG   = 8'h5C;
  localparam int         T_RES = 20;
  localparam int         HDR   = 32;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, mosi;
  logic miso_o, miso_oe, busy;
  logic [1:0] pwr_state;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic oe;
    logic b;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  dpd_release_resp #(
    .SIGNATURE   (SIG),
    .DUMMY_BYTES (3),
    .T_RES_CYCLES(T_RES),
    .RESET_IN_DPD(1'b1)
  ) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .mosi     (mosi),
    .miso_o   (miso_o),
    .miso_oe  (miso_oe),
    .pwr_state(pwr_state),
    .busy     (busy)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Monitor: compares what the host would sample at each rising SCK edge
  always @(posedge sck) begin
    if (!cs_n) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "scoreboard underflow", 0, 1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(miso_oe == e.oe, e.oe ? "R4" : "R3", "miso_oe at SCK rise",
            int'(miso_oe), int'(e.oe));
        if (e.oe)
          chk(miso_o == e.b, "R4", "signature bit", int'(miso_o), int'(e.b));
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: one SCK period, pushing the expected sample before the rise
  task automatic sck_cycle(input logic din, input logic e_oe, input logic e_b);
    exp_t e;
    mosi = din;
    sck  = 1'b0;
    wait_clk(4);
    e.oe = e_oe;
    e.b  = e_b;
    exp_q.push_back(e);
    sck = 1'b1;
    wait_clk(4);
  endtask

  task automatic run_frame(input logic [7:0] op, input int nrise, input bit answers);
    cs_n = 1'b0;
    wait_clk(4);
    for (int k = 1; k <= nrise; k++) begin
      logic din, eo, eb;
      din = (k <= 8) ? op[8-k] : 1'b0;
      eo  = answers && (k > HDR);
      eb  = eo ? SIG[7 - ((k - HDR - 1) % 8)] : 1'b0;
      sck_cycle(din, eo, eb);
    end
    sck = 1'b0;
    wait_clk(4);
    cs_n = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cs_n  = 1'b1;
    sck   = 1'b0;
    mosi  = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1 run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();
    // R1: reset state
    chk(pwr_state == 2'b01, "R1", "pwr_state after reset", pwr_state, 1);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(miso_oe == 1'b0, "R1", "miso_oe after reset", miso_oe, 0);

    // R2: wrong opcode, no output, state unchanged
    run_frame(8'h9F, 48, 1'b0);
    wait_clk(8);
    chk(pwr_state == 2'b01, "R2", "state after foreign opcode", pwr_state, 1);
    chk(busy == 1'b0, "R2", "busy after foreign opcode", busy, 0);
    chk(miso_oe == 1'b0, "R5", "miso_oe with cs high", miso_oe, 0);

    // R7: abort during signature
    run_frame(8'hAB, 36, 1'b1);
    wait_clk(8);
    chk(pwr_state == 2'b01, "R7", "state after aborted read", pwr_state, 1);
    chk(busy == 1'b0, "R7", "busy after aborted read", busy, 0);
    chk(miso_oe == 1'b0, "R5", "miso_oe with cs high", miso_oe, 0);

    // R6 and R4 repeat: full read twice, then timed wake
    run_frame(8'hAB, 48, 1'b1);
    n = 0;
    while (!busy && n < 10) begin
      wait_clk(1);
      n++;
    end
    chk(busy == 1'b1, "R6", "busy rises after cs high", busy, 1);
    chk(pwr_state == 2'b10, "R6", "waking state", pwr_state, 2);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      wait_clk(1);
    end
    chk(n == T_RES, "R6", "busy length in cycles", n, T_RES);
    chk(pwr_state == 2'b00, "R6", "standby after wake", pwr_state, 0);

    // R8: command from standby, stays standby with no busy
    run_frame(8'hAB, 40, 1'b1);
    n = 0;
    for (int i = 0; i < 30; i++) begin
      wait_clk(1);
      if (busy) n++;
    end
    chk(n == 0, "R8", "busy cycles from standby", n, 0);
    chk(pwr_state == 2'b00, "R8", "standby kept", pwr_state, 0);
    chk(miso_oe == 1'b0, "R5", "miso_oe with cs high", miso_oe, 0);

    // R9: a frame opened while waking is ignored
    do_reset();
    chk(pwr_state == 2'b01, "R1", "pwr_state after second reset", pwr_state, 1);
    run_frame(8'hAB, 40, 1'b1);
    n = 0;
    while (!busy && n < 10) begin
      wait_clk(1);
      n++;
    end
    chk(busy == 1'b1, "R9", "busy before ignored frame", busy, 1);
    run_frame(8'hAB, 48, 1'b0);
    wait_clk(8);
    chk(pwr_state == 2'b00, "R9", "standby reached during ignored frame", pwr_state, 0);
    chk(busy == 1'b0, "R9", "busy cleared", busy, 0);
    chk(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule